// File: doc/BRIEF.md
# Dual-Bus Multi-Channel Byte Mover

This block moves bytes between two buses of very different shape. The wide linear bus ("A side") carries a 24-bit address. The narrow paged bus ("B side") is reached as a fixed page plus an 8-bit register offset. Every transfer has one endpoint on each side. Each of the eight channels holds a direction, an A-side address, a B-side offset, a byte count and an A-address stepping rule. Software writes an enable mask to a start register. The block then raises a halt output that stops the processor. It works through the enabled channels one at a time, lowest number first, and moves one byte per clock. When the last enabled channel finishes, it drops the halt.

The block also holds a work-RAM that both buses can reach. On the A side, one bank maps straight onto its storage. On the B side, four offsets form a streaming window: three load a 17-bit pointer, and the fourth reads or writes the byte at that pointer and then advances it. If a single transfer cycle selects both work-RAM ports, the A-side access is served. The B-side access is then suppressed and a B-side read returns the last value seen on the data bus (open bus).

The processor reaches everything through one port when it is not halted. Bank 0x00, page 0x21 goes to the B side. Bank 0x00, page 0x43 goes to the channel registers. The work-RAM bank 0x7E goes to the direct port. Any other address goes to the external A bus.

Top module: `dualbus_dma`

## Requirements
- R1: After reset `cpu_halt`, `a_re`, `a_we`, `b_re` and `b_we` are all low.
- R2: When the direction bit (bit 0 of channel field 0) is 0, the channel reads the A side at its address and writes each byte to its fixed B offset. It moves one byte per clock and keeps the order of the bytes.
- R3: When the direction bit is 1, the channel reads its B offset and writes each byte to the A side at its address, one byte per clock.
- R4: After each byte the A address steps according to bits 2:1 of field 0. 00 increments, 01 decrements, 10 and 11 leave it unchanged.
- R5: A byte count of 0 moves 65536 bytes.
- R6: The start register sits at offset 0xF0 of the control page and takes a channel mask in bits 7:0. Enabled channels run in ascending channel number, and each finishes before the next one starts.
- R7: `cpu_halt` rises on the clock after a start write with a nonzero mask. It stays high for exactly the total number of bytes moved. A start write with mask 0 leaves it low.
- R8: A channel keeps its stepped A address after it completes. A later start that rewrites only the count (fields 5 and 6) carries on from the next address.
- R9: The B-side streaming window loads its pointer through offsets 0x81, 0x82 and 0x83 (bits 7:0, 15:8 and 16). Offset 0x80 reads or writes the byte at the pointer and then increments the pointer. This holds for both processor and channel accesses.
- R10: A-side bank 0x7E reaches the same work-RAM storage directly, using the low address bits.
- R11: If a channel reads the work-RAM bank and writes B offset 0x80 in the same cycle, the B-side write is dropped and the stream pointer does not advance.
- R12: If a channel reads B offset 0x80 and writes the work-RAM bank in the same cycle, the byte written is the last value seen on the data bus (open bus) and the stream pointer does not advance.
- R13: Channel registers use offset {channel, field} on the control page. Field 1 is the B offset, fields 2, 3 and 4 are the A address from low byte to high byte, and fields 5 and 6 are the count low and high bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_en | input | 1 | Processor access request for this cycle (ignored while halted) |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | 24 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, combinational |
| cpu_halt | output | 1 | Stalls the processor while channels run |
| a_addr | output | 24 | External A-side address |
| a_re | output | 1 | External A-side read strobe |
| a_we | output | 1 | External A-side write strobe |
| a_wdata | output | 8 | External A-side write data |
| a_rdata | input | 8 | External A-side read data, asynchronous |
| b_off | output | 8 | External B-side register offset |
| b_re | output | 1 | External B-side read strobe |
| b_we | output | 1 | External B-side write strobe |
| b_wdata | output | 8 | External B-side write data |
| b_rdata | input | 8 | External B-side read data, asynchronous |

## Verification
The bench builds the block with its default parameters: eight channels, a 24-bit A side, a 16-bit count, a 17-bit stream pointer and a 256-byte work-RAM. Because the work-RAM is this small, every byte the conflict cases could disturb can be read back directly through the A-side bank. Because the count is 16 bits, the 65536-byte case of a zero count fits inside one run. A mask covering two channels lets the bench observe their ordering on the external B-side strobes.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int A_W   = 24;
  localparam int CNT_W = 16;
  localparam int D_W   = 8;

  // control-page field numbers inside a channel slot
  localparam logic [3:0] FLD_MODE  = 4'd0;
  localparam logic [3:0] FLD_BOFF  = 4'd1;
  localparam logic [3:0] FLD_A_LO  = 4'd2;
  localparam logic [3:0] FLD_A_MID = 4'd3;
  localparam logic [3:0] FLD_A_HI  = 4'd4;
  localparam logic [3:0] FLD_CNT_L = 4'd5;
  localparam logic [3:0] FLD_CNT_H = 4'd6;

  typedef enum logic [1:0] {
    STEP_INC  = 2'd0,
    STEP_DEC  = 2'd1,
    STEP_HOLD = 2'd2,
    STEP_HLD2 = 2'd3
  } step_e;

  typedef struct packed {
    logic             to_a;   // 1: B side -> A side
    step_e            step;
    logic [D_W-1:0]   b_off;
    logic [A_W-1:0]   a_addr;
    logic [CNT_W-1:0] count;
  } chan_cfg_t;

  function automatic logic [A_W-1:0] step_addr(input logic [A_W-1:0] a, input step_e st);
    case (st)
      STEP_INC: step_addr = a + A_W'(1);
      STEP_DEC: step_addr = a - A_W'(1);
      default:  step_addr = a;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] c);
    count_dec = c - CNT_W'(1);
  endfunction

  // a count of one means the byte now moving is the last one; zero wraps to full range
  function automatic logic count_is_last(input logic [CNT_W-1:0] c);
    count_is_last = (c == CNT_W'(1));
  endfunction

  function automatic logic is_stream_off(input logic [D_W-1:0] off);
    is_stream_off = (off[D_W-1:2] == 6'b100000);
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [3:0]      wr_field,
  input  logic [D_W-1:0]  wr_data,
  input  logic            adv_en,
  input  logic [CH_W-1:0] adv_ch,
  output chan_cfg_t       cfg_o [NCH]
);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    chan_cfg_t cfg_q;
    logic      hit_wr, hit_adv;

    assign hit_wr  = wr_en  && (wr_ch  == CH_W'(g));
    assign hit_adv = adv_en && (adv_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (hit_wr) begin
        case (wr_field)
          FLD_MODE: begin
            cfg_q.to_a <= wr_data[0];
            cfg_q.step <= step_e'(wr_data[2:1]);
          end
          FLD_BOFF:  cfg_q.b_off         <= wr_data;
          FLD_A_LO:  cfg_q.a_addr[7:0]   <= wr_data;
          FLD_A_MID: cfg_q.a_addr[15:8]  <= wr_data;
          FLD_A_HI:  cfg_q.a_addr[23:16] <= wr_data;
          FLD_CNT_L: cfg_q.count[7:0]    <= wr_data;
          FLD_CNT_H: cfg_q.count[15:8]   <= wr_data;
          default: ;
        endcase
      end else if (hit_adv) begin
        cfg_q.a_addr <= step_addr(cfg_q.a_addr, cfg_q.step);
        cfg_q.count  <= count_dec(cfg_q.count);
      end
    end

    assign cfg_o[g] = cfg_q;
  end

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic [NCH-1:0]  mask,
  output logic [CH_W-1:0] grant,
  output logic            any
);

  // fixed priority: the lowest set bit wins
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        grant = CH_W'(i);
        any   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wram_dual.sv
module wram_dual
  import dma_pkg::*;
#(
  parameter int DL   = 8,
  parameter int SA_W = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  // direct port (A side)
  input  logic            a_sel,
  input  logic            a_we,
  input  logic [DL-1:0]   a_idx,
  input  logic [D_W-1:0]  a_wdata,
  output logic [D_W-1:0]  a_rdata,
  // streaming window (B side)
  input  logic            b_sel,
  input  logic            b_we,
  input  logic [1:0]      b_reg,
  input  logic [D_W-1:0]  b_wdata,
  output logic [D_W-1:0]  b_rdata,
  output logic            b_drive,
  output logic            conflict,
  output logic [SA_W-1:0] saddr_o
);

  localparam int DEPTH = 1 << DL;

  logic [D_W-1:0]  mem [DEPTH];
  logic [SA_W-1:0] saddr;
  logic            b_data_sel, b_go, b_data_go;

  assign b_data_sel = b_sel && (b_reg == 2'd0);
  assign conflict   = a_sel && b_data_sel;   // the direct side wins
  assign b_go       = b_sel && !conflict;
  assign b_data_go  = b_go && (b_reg == 2'd0);

  assign a_rdata = mem[a_idx];
  assign b_rdata = mem[saddr[DL-1:0]];
  assign b_drive = b_data_go && !b_we;
  assign saddr_o = saddr;

  always_ff @(posedge clk) begin
    if (a_sel && a_we)
      mem[a_idx] <= a_wdata;
    else if (b_data_go && b_we)
      mem[saddr[DL-1:0]] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saddr <= '0;
    end else if (b_data_go) begin
      saddr <= saddr + SA_W'(1);
    end else if (b_go && b_we) begin
      case (b_reg)
        2'd1:    saddr[7:0]       <= b_wdata;
        2'd2:    saddr[15:8]      <= b_wdata;
        default: saddr[SA_W-1:16] <= b_wdata[SA_W-17:0];
      endcase
    end
  end

endmodule

// File: rtl/dualbus_dma.sv
module dualbus_dma
  import dma_pkg::*;
#(
  parameter int         NCH        = 8,
  parameter int         WRAM_DL    = 8,
  parameter int         WRAM_SA_W  = 17,
  parameter logic [7:0] WRAM_BANK  = 8'h7E,
  parameter logic [7:0] B_PAGE     = 8'h21,
  parameter logic [7:0] CTRL_PAGE  = 8'h43,
  parameter logic [7:0] START_OFF  = 8'hF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_en,
  input  logic            cpu_we,
  input  logic [23:0]     cpu_addr,
  input  logic [7:0]      cpu_wdata,
  output logic [7:0]      cpu_rdata,
  output logic            cpu_halt,
  output logic [23:0]     a_addr,
  output logic            a_re,
  output logic            a_we,
  output logic [7:0]      a_wdata,
  input  logic [7:0]      a_rdata,
  output logic [7:0]      b_off,
  output logic            b_re,
  output logic            b_we,
  output logic [7:0]      b_wdata,
  input  logic [7:0]      b_rdata
);

  localparam int         CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [3:0] NCH4 = 4'(NCH);

  // engine state
  logic           running;
  logic [NCH-1:0] en_mask;
  logic [7:0]     bus_latch;

  // processor decode
  logic cpu_go, cpu_is_b, cpu_is_ctrl, cpu_is_wram, cpu_is_a;
  assign cpu_go      = cpu_en && !running;
  assign cpu_is_b    = (cpu_addr[23:16] == 8'h00) && (cpu_addr[15:8] == B_PAGE);
  assign cpu_is_ctrl = (cpu_addr[23:16] == 8'h00) && (cpu_addr[15:8] == CTRL_PAGE);
  assign cpu_is_wram = (cpu_addr[23:16] == WRAM_BANK);
  assign cpu_is_a    = !cpu_is_b && !cpu_is_ctrl;

  // named internal events
  logic            start_wr, cfg_wr, xfer, last_byte;
  logic [CH_W-1:0] grant;
  logic            grant_any;
  logic [NCH-1:0]  mask_rest;
  logic [CNT_W-1:0] cur_count;
  logic            conflict;
  logic [WRAM_SA_W-1:0] wr_saddr;

  assign start_wr = cpu_go && cpu_we && cpu_is_ctrl && (cpu_addr[7:0] == START_OFF);
  assign cfg_wr   = cpu_go && cpu_we && cpu_is_ctrl && (cpu_addr[7:4] < NCH4);

  chan_cfg_t cfg [NCH];
  chan_cfg_t cur;

  dma_arbiter #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .mask (en_mask),
    .grant(grant),
    .any  (grant_any)
  );

  assign xfer      = running && grant_any;
  assign cur       = cfg[grant];
  assign cur_count = cur.count;
  assign last_byte = count_is_last(cur.count);
  assign mask_rest = en_mask & ~(NCH'(1) << grant);

  dma_chan_regs #(.NCH(NCH), .CH_W(CH_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_ch   (cpu_addr[4 +: CH_W]),
    .wr_field(cpu_addr[3:0]),
    .wr_data (cpu_wdata),
    .adv_en  (xfer),
    .adv_ch  (grant),
    .cfg_o   (cfg)
  );

  // A-side access (engine or processor)
  logic        a_valid, a_is_wr, a_in_wram;
  logic [23:0] a_addr_sel;
  logic [7:0]  a_read_val, a_wd;
  assign a_valid    = xfer || (cpu_go && cpu_is_a);
  assign a_addr_sel = xfer ? cur.a_addr : cpu_addr;
  assign a_is_wr    = xfer ? cur.to_a : cpu_we;
  assign a_in_wram  = (a_addr_sel[23:16] == WRAM_BANK);

  // B-side access (engine or processor)
  logic       b_valid, b_is_wr, b_in_wram;
  logic [7:0] b_off_sel, b_read_val, b_eff, b_wd;
  logic       b_read_drv;
  assign b_valid   = xfer || (cpu_go && cpu_is_b);
  assign b_off_sel = xfer ? cur.b_off : cpu_addr[7:0];
  assign b_is_wr   = xfer ? !cur.to_a : cpu_we;
  assign b_in_wram = is_stream_off(b_off_sel);

  // work-RAM on both sides
  logic [7:0] wr_a_rdata, wr_b_rdata;
  logic       wr_b_drive;

  wram_dual #(.DL(WRAM_DL), .SA_W(WRAM_SA_W)) u_wram (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_sel   (a_valid && a_in_wram),
    .a_we    (a_is_wr),
    .a_idx   (a_addr_sel[WRAM_DL-1:0]),
    .a_wdata (a_wd),
    .a_rdata (wr_a_rdata),
    .b_sel   (b_valid && b_in_wram),
    .b_we    (b_is_wr),
    .b_reg   (b_off_sel[1:0]),
    .b_wdata (b_wd),
    .b_rdata (wr_b_rdata),
    .b_drive (wr_b_drive),
    .conflict(conflict),
    .saddr_o (wr_saddr)
  );

  assign a_read_val = a_in_wram ? wr_a_rdata : a_rdata;
  assign b_read_drv = b_in_wram ? wr_b_drive : 1'b1;
  assign b_read_val = b_in_wram ? wr_b_rdata : b_rdata;
  assign b_eff      = b_read_drv ? b_read_val : bus_latch;

  // the byte being moved this cycle
  logic [7:0] mv_data;
  assign mv_data = cur.to_a ? b_eff : a_read_val;

  assign a_wd = xfer ? mv_data : cpu_wdata;
  assign b_wd = xfer ? mv_data : cpu_wdata;

  // external strobes
  assign a_addr  = a_addr_sel;
  assign a_re    = a_valid && !a_in_wram && !a_is_wr;
  assign a_we    = a_valid && !a_in_wram &&  a_is_wr;
  assign a_wdata = a_wd;
  assign b_off   = b_off_sel;
  assign b_re    = b_valid && !b_in_wram && !b_is_wr;
  assign b_we    = b_valid && !b_in_wram &&  b_is_wr;
  assign b_wdata = b_wd;

  always_comb begin
    if (cpu_is_b)      cpu_rdata = b_eff;
    else if (cpu_is_a) cpu_rdata = a_read_val;
    else               cpu_rdata = bus_latch;
  end

  assign cpu_halt = running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      en_mask   <= '0;
      bus_latch <= '0;
    end else begin
      if (start_wr) begin
        en_mask <= cpu_wdata[NCH-1:0];
        running <= |cpu_wdata[NCH-1:0];
      end else if (xfer && last_byte) begin
        en_mask <= mask_rest;
        running <= |mask_rest;
      end
      if (xfer)
        bus_latch <= mv_data;
      else if (cpu_go)
        bus_latch <= cpu_we ? cpu_wdata : cpu_rdata;
    end
  end

endmodule

// File: rtl/dualbus_dma_chk.sv
module dualbus_dma_chk #(
  parameter int NCH  = 8,
  parameter int CH_W = 3,
  parameter int SA_W = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_halt,
  input logic [7:0]      cpu_wdata,
  input logic            start_wr,
  input logic            xfer,
  input logic            last_byte,
  input logic [CH_W-1:0] grant,
  input logic [15:0]     cur_count,
  input logic [NCH-1:0]  mask_rest,
  input logic            conflict,
  input logic [SA_W-1:0] wr_saddr
);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !cpu_halt); // R1

  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !last_byte |=> cur_count == $past(cur_count) - 16'd1); // R2

  AST_CHANNEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !last_byte |=> grant == $past(grant)); // R6

  AST_HALT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && (cpu_wdata[NCH-1:0] != '0) |=> cpu_halt); // R7

  AST_HALT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && last_byte && (mask_rest == '0) |=> !cpu_halt); // R7

  AST_CONFLICT_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> wr_saddr == $past(wr_saddr)); // R11

endmodule

bind dualbus_dma dualbus_dma_chk #(.NCH(NCH), .CH_W(CH_W), .SA_W(WRAM_SA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_halt (cpu_halt),
  .cpu_wdata(cpu_wdata),
  .start_wr (start_wr),
  .xfer     (xfer),
  .last_byte(last_byte),
  .grant    (grant),
  .cur_count(cur_count),
  .mask_rest(mask_rest),
  .conflict (conflict),
  .wr_saddr (wr_saddr)
);

// File: tb/dualbus_dma_tb.sv
module dualbus_dma_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_en = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_halt;
  logic [23:0] a_addr;
  logic        a_re, a_we, b_re, b_we;
  logic [7:0]  a_wdata, a_rdata, b_off, b_wdata, b_rdata;

  always #2.5 clk = ~clk;

  dualbus_dma u_dut (.*);

  // external devices: asynchronous memories; B registers count up on each read
  logic [7:0] a_mem [1024];
  logic [7:0] b_mem [256];
  assign a_rdata = a_mem[a_addr[9:0]];
  assign b_rdata = b_mem[b_off];
  always @(posedge clk) begin
    if (a_we) a_mem[a_addr[9:0]] <= a_wdata;
    if (b_we) b_mem[b_off] <= b_wdata;
    if (b_re) b_mem[b_off] <= b_mem[b_off] + 8'd1;
  end

  int n_checks = 0, n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_b;
    logic [23:0] addr;
    logic [7:0]  data;
    string       tag;
  } item_t;
  item_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every external write strobe is matched against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && (a_we || b_we)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected write", {7'd0, b_we, a_we ? a_addr : {16'd0, b_off}}, 32'd0);
      end else begin
        item_t it;
        logic [23:0] got_addr;
        logic [7:0]  got_data;
        it = exp_q.pop_front();
        got_addr = b_we ? {16'd0, b_off} : a_addr;
        got_data = b_we ? b_wdata : a_wdata;
        chk((b_we == it.is_b) && (got_addr == it.addr) && (got_data == it.data),
            it.tag, {got_addr, got_data}, {it.addr, it.data});
      end
    end
  end

  function automatic logic [23:0] nxt(input logic [23:0] a, input int mode);
    if (mode == 0) return a + 24'd1;
    if (mode == 1) return a - 24'd1;
    return a;
  endfunction

  task automatic cpu_wr(input logic [23:0] addr, input logic [7:0] data);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = addr; cpu_wdata = data;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [23:0] addr, output logic [7:0] data);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b0; cpu_addr = addr;
    #1 data = cpu_rdata;
    @(negedge clk);
    cpu_en = 1'b0;
  endtask

  function automatic logic [23:0] creg(input int ch, input int fld);
    return {16'h0043, 4'(ch), 4'(fld)};
  endfunction

  task automatic cfg_chan(input int ch, input bit to_a, input int step, input logic [7:0] boff,
                          input logic [23:0] aaddr, input logic [15:0] cnt);
    cpu_wr(creg(ch, 0), {5'd0, 2'(step), to_a});
    cpu_wr(creg(ch, 1), boff);
    cpu_wr(creg(ch, 2), aaddr[7:0]);
    cpu_wr(creg(ch, 3), aaddr[15:8]);
    cpu_wr(creg(ch, 4), aaddr[23:16]);
    cpu_wr(creg(ch, 5), cnt[7:0]);
    cpu_wr(creg(ch, 6), cnt[15:8]);
  endtask

  // driver: expected external writes for A->B and B->A runs
  task automatic exp_ab(input logic [23:0] a0, input int step, input logic [7:0] boff,
                        input int n, input string tag);
    logic [23:0] a = a0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{1'b1, {16'd0, boff}, a_mem[a[9:0]], tag});
      a = nxt(a, step);
    end
  endtask

  task automatic exp_ba(input logic [23:0] a0, input int step, input logic [7:0] boff,
                        input int n, input string tag);
    logic [23:0] a = a0;
    logic [7:0]  v = b_mem[boff];
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{1'b0, a, v, tag});
      a = nxt(a, step);
      v = v + 8'd1;
    end
  endtask

  task automatic run(input logic [7:0] mask, input int n_exp, input string tag);
    int n = 0;
    cpu_wr(24'h0043F0, mask);
    while (cpu_halt) begin
      n++;
      @(negedge clk);
    end
    @(negedge clk);
    chk(n == n_exp, {tag, " halt length"}, n, n_exp);
    chk(exp_q.size() == 0, {tag, " all bytes seen"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    for (int i = 0; i < 1024; i++) a_mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 256; i++)  b_mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!cpu_halt, "R1 halt after reset", cpu_halt, 0);
    chk(!(a_re || a_we || b_re || b_we), "R1 strobes after reset", {a_re, a_we, b_re, b_we}, 0);

    // R2 A->B incrementing, R13 register layout
    cfg_chan(0, 1'b0, 0, 8'h18, 24'h000010, 16'd4);
    exp_ab(24'h000010, 0, 8'h18, 4, "R2 A to B inc");
    run(8'h01, 4, "R2");

    // R3 B->A with R4 decrement
    cfg_chan(1, 1'b1, 1, 8'h20, 24'h000100, 16'd3);
    exp_ba(24'h000100, 1, 8'h20, 3, "R3 B to A dec R4");
    run(8'h02, 3, "R3");

    // R4 fixed address (step code 2)
    cfg_chan(2, 1'b0, 2, 8'h19, 24'h000020, 16'd3);
    exp_ab(24'h000020, 2, 8'h19, 3, "R4 fixed address");
    run(8'h04, 3, "R4");

    // R6 priority: channels 1 and 3 together, channel 1 completes first
    cfg_chan(3, 1'b0, 0, 8'h31, 24'h000300, 16'd2);
    cfg_chan(1, 1'b0, 0, 8'h30, 24'h000200, 16'd2);
    exp_ab(24'h000200, 0, 8'h30, 2, "R6 ch1 first");
    exp_ab(24'h000300, 0, 8'h31, 2, "R6 ch3 second");
    run(8'h0A, 4, "R6");

    // R8 channel 0 resumes at 0x14 after its count alone is rewritten
    cpu_wr(creg(0, 5), 8'd2);
    cpu_wr(creg(0, 6), 8'd0);
    exp_ab(24'h000014, 0, 8'h18, 2, "R8 resume address");
    run(8'h01, 2, "R8");

    // R7 mask zero keeps halt low
    cpu_wr(24'h0043F0, 8'h00);
    for (int i = 0; i < 3; i++) begin
      chk(!cpu_halt, "R7 empty mask no halt", cpu_halt, 0);
      @(negedge clk);
    end

    // R5 count zero moves 65536 bytes
    cfg_chan(4, 1'b0, 2, 8'h1A, 24'h000033, 16'd0);
    exp_ab(24'h000033, 2, 8'h1A, 65536, "R5 count zero");
    run(8'h10, 65536, "R5");

    // R9 R10 processor stream writes seen through the direct bank
    cpu_wr(24'h002181, 8'h05);
    cpu_wr(24'h002182, 8'h00);
    cpu_wr(24'h002183, 8'h00);
    cpu_wr(24'h002180, 8'hA1);
    cpu_wr(24'h002180, 8'hA2);
    cpu_rd(24'h7E0005, rd); chk(rd == 8'hA1, "R10 direct sees stream 0", rd, 8'hA1);
    cpu_rd(24'h7E0006, rd); chk(rd == 8'hA2, "R9 stream increments", rd, 8'hA2);

    // R9 engine writes into the stream window from the external A side
    cpu_wr(24'h002181, 8'h20);
    cfg_chan(6, 1'b0, 0, 8'h80, 24'h000040, 16'd3);
    run(8'h40, 3, "R9 engine stream");
    for (int i = 0; i < 3; i++) begin
      cpu_rd(24'h7E0020 + 24'(i), rd);
      chk(rd == a_mem[10'h40 + 10'(i)], "R9 engine stream byte", rd, a_mem[10'h40 + 10'(i)]);
    end

    // R11 work-RAM source and stream destination collide
    cpu_wr(24'h7E0030, 8'h99);
    cpu_wr(24'h7E0031, 8'h98);
    cpu_wr(24'h7E0040, 8'h11);
    cpu_wr(24'h7E0041, 8'h22);
    cpu_wr(24'h7E0042, 8'h33);
    cpu_wr(24'h002181, 8'h40);
    cfg_chan(7, 1'b0, 0, 8'h80, 24'h7E0030, 16'd2);
    run(8'h80, 2, "R11");
    cpu_rd(24'h7E0040, rd); chk(rd == 8'h11, "R11 stream write dropped", rd, 8'h11);
    cpu_rd(24'h002180, rd); chk(rd == 8'h11, "R11 pointer held", rd, 8'h11);

    // R12 stream source and work-RAM destination collide: open bus holds the mask byte
    cpu_wr(24'h7E0050, 8'h44);
    cpu_wr(24'h002181, 8'h50);
    cfg_chan(5, 1'b1, 0, 8'h80, 24'h7E0060, 16'd2);
    run(8'h20, 2, "R12");
    cpu_rd(24'h7E0060, rd); chk(rd == 8'h20, "R12 open bus byte 0", rd, 8'h20);
    cpu_rd(24'h7E0061, rd); chk(rd == 8'h20, "R12 open bus byte 1", rd, 8'h20);
    cpu_rd(24'h002180, rd); chk(rd == 8'h44, "R12 pointer held", rd, 8'h44);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule